// File: doc/BRIEF.md
# I2C Transfer Sequencer

This block runs a single I2C message on a status-code-driven I2C master engine, with no software in the loop. The caller sets the target address, the address width, the direction flags, an optional no-start mode, a byte count and a cycle timeout, then pulses `start`. Each time the engine raises its interrupt flag, the sequencer reads the engine's status byte and decodes the next step from it. It then writes the engine's data and control registers over a simple register bus.

Bytes to send come from a pop-style stream port. Received bytes leave on a valid-qualified output. The transfer ends with a one-cycle `done` pulse and a result code. Abort is supported in two ways: an external request, or a first timeout expiry. Either one winds the transfer down at the next safe point. A second timeout expiry resets the engine and closes the transfer.

Top module: `i2c_xfer_seq`

## Requirements
- R1: After reset, `bus_wr`, `bus_rd`, `busy`, `done`, `tx_pop` and `rx_valid` are all low.
- R2: The register map is 0 data, 1 control, 2 status (read), 3 soft reset (write). Read data arrives on `bus_rdata` one cycle after `bus_rd`. Control bits are: bit0 engine enable, bit1 interrupt enable, bit2 ACK enable, bit3 start, bit4 stop. A normal transfer opens with a control write of 0x0F. Every decision is preceded by a status read. Every continuing step ends with a control write of the current control word, which is 0x07 unless ACK has been cleared.
- R3: A 7-bit address goes out as the single data byte {addr[6:0], dir}. Here dir = `rd` XOR `rev_dir`.
- R4: A 10-bit address goes out as {5'b11110, addr[9:8], dir} after status 0x08 or 0x10. After status 0x18 or 0x40, it is followed by addr[7:0].
- R5: On write statuses 0x18 (7-bit mode), 0xD0 and 0x28, the next stream byte is written to the data register and popped. This repeats until the length is used up. At that point a stop is issued: the control word with interrupt enable cleared and bit4 set (0x15). `done` then reports result 0 (OK).
- R6: Status 0x50 reads the data register and presents the byte on `rx_data`. When only one byte is left after it, the following control write has ACK cleared. Status 0x58 reads the final byte and then stops.
- R7: A read whose length is zero stops as soon as its address is acknowledged (0x40 or 0xE0), with result OK.
- R8: Statuses 0x20, 0x30 and 0x48 stop the transfer with result 1 (no device).
- R9: Any other status causes a soft-reset register write, then a control write of 0x11, and reports result 2 (I/O error).
- R10: With an abort pending, a write stops at the first acknowledge after at least one data byte has gone out. A read clears ACK at its next control write.
- R11: The first timeout expiry (`timeout_lim` busy cycles) acts as an abort, and the transfer reports result 3. A second expiry writes soft reset, then control 0x11, and reports result 3.
- R12: An interrupt flag that arrives while idle is answered with a control write that has bit4 set. No `done` pulse follows.
- R13: In no-start mode, a write sends its first data byte immediately with a plain control write. A read issues a plain control write and waits for data.
- R14: At most one bus access happens per cycle. `done` coincides with the closing stop control write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a message (taken when idle) |
| tgt_addr | input | 10 | Target address |
| ten_bit | input | 1 | 10-bit addressing |
| rd | input | 1 | Read message |
| rev_dir | input | 1 | Invert the direction bit |
| no_start | input | 1 | Skip the start and address phases |
| xfer_len | input | LEN_W | Byte count |
| abort_req | input | 1 | Request a graceful abort |
| timeout_lim | input | TO_W | Busy cycles per timeout stage |
| tx_data | input | 8 | Next byte to send |
| tx_pop | output | 1 | `tx_data` consumed |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | `rx_data` valid |
| eng_irq | input | 1 | Engine interrupt flag |
| bus_wr | output | 1 | Register write strobe |
| bus_rd | output | 1 | Register read strobe |
| bus_addr | output | 2 | Register index |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data (one cycle after `bus_rd`) |
| busy | output | 1 | Message in progress |
| done | output | 1 | Message finished |
| result | output | 2 | 0 OK, 1 no device, 2 I/O error, 3 timeout |

## Verification
The sequencer is driven by an engine model in the bench that replays scripted status sequences, and every bus access is compared in order against a reference trace. The first group of patterns covers 7-bit writes, reversed-direction reads, 10-bit writes and zero-length 10-bit reads. These separate address byte formation, byte ordering and the timing of the last-byte ACK clear. The second group covers no-acknowledge statuses, an unexpected status, and both no-start variants. These show that errors, engine reset and phase skipping each follow their own path. The last group covers an external abort, a late status after the first timeout, and total silence until the second timeout, plus a stray flag while idle. These distinguish a graceful wind-down from a forced engine reset.

// File: rtl/i2cseq_pkg.sv
package i2cseq_pkg;

  typedef enum logic [2:0] {
    XS_IDLE, XS_WSTART, XS_WADDR1, XS_WADDR2, XS_WACK, XS_WDATA
  } xstate_t;

  typedef enum logic [3:0] {
    ACT_CONT, ACT_START, ACT_ADDR1, ACT_ADDR2, ACT_SEND,
    ACT_RECV, ACT_RECV_STOP, ACT_STOP, ACT_RESET_STOP
  } act_t;

  typedef enum logic [1:0] {
    RES_OK, RES_NODEV, RES_EIO, RES_TIMEOUT
  } res_t;

  typedef enum logic [2:0] {
    U_WAIT, U_STAT, U_DRD, U_DCAP, U_DWR, U_SRST, U_CTL
  } ustate_t;

  localparam logic [1:0] REG_DATA = 2'd0;
  localparam logic [1:0] REG_CTL  = 2'd1;
  localparam logic [1:0] REG_STAT = 2'd2;
  localparam logic [1:0] REG_SRST = 2'd3;

  localparam logic [7:0] CTL_EN    = 8'h01;
  localparam logic [7:0] CTL_IE    = 8'h02;
  localparam logic [7:0] CTL_ACK   = 8'h04;
  localparam logic [7:0] CTL_START = 8'h08;
  localparam logic [7:0] CTL_STOP  = 8'h10;

  localparam logic [7:0] ST_START     = 8'h08;
  localparam logic [7:0] ST_RESTART   = 8'h10;
  localparam logic [7:0] ST_WA_ACK    = 8'h18;
  localparam logic [7:0] ST_WA_NACK   = 8'h20;
  localparam logic [7:0] ST_WD_ACK    = 8'h28;
  localparam logic [7:0] ST_WD_NACK   = 8'h30;
  localparam logic [7:0] ST_RA_ACK    = 8'h40;
  localparam logic [7:0] ST_RA_NACK   = 8'h48;
  localparam logic [7:0] ST_RD_ACK    = 8'h50;
  localparam logic [7:0] ST_RD_NACK   = 8'h58;
  localparam logic [7:0] ST_WA2_ACK   = 8'hD0;
  localparam logic [7:0] ST_RA2_ACK   = 8'hE0;

endpackage

// File: rtl/i2cseq_addr.sv
module i2cseq_addr (
  input  logic [9:0] addr,
  input  logic       ten,
  input  logic       rd,
  input  logic       rev,
  output logic [7:0] first_byte,
  output logic [7:0] second_byte
);
  logic dir;

  always_comb begin
    dir = rd ^ rev;
    if (ten) begin
      first_byte  = {5'b11110, addr[9:8], dir};
      second_byte = addr[7:0];
    end else begin
      first_byte  = {addr[6:0], dir};
      second_byte = 8'h00;
    end
  end
endmodule

// File: rtl/i2cseq_decode.sv
module i2cseq_decode
  import i2cseq_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic [7:0]       status,
  input  logic             ten,
  input  logic [LEN_W-1:0] left,
  input  logic             sent_any,
  input  logic             abort,
  output act_t             act,
  output xstate_t          nxt,
  output logic             dec_left,
  output logic             clr_ack,
  output logic             fail,
  output res_t             fail_res
);
  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);
  localparam logic [LEN_W-1:0] TWO = LEN_W'(2);

  always_comb begin
    act      = ACT_RESET_STOP;
    nxt      = XS_IDLE;
    dec_left = 1'b0;
    clr_ack  = 1'b0;
    fail     = 1'b0;
    fail_res = RES_EIO;
    case (status)
      ST_START, ST_RESTART: begin
        act = ACT_ADDR1;
        nxt = XS_WADDR1;
      end
      ST_WA_ACK, ST_WA2_ACK, ST_WD_ACK: begin
        if (status == ST_WA_ACK && ten) begin
          act = ACT_ADDR2;
          nxt = XS_WADDR2;
        end else if (left == '0 || (abort && sent_any)) begin
          act = ACT_STOP;
        end else begin
          act      = ACT_SEND;
          nxt      = XS_WACK;
          dec_left = 1'b1;
        end
      end
      ST_RA_ACK, ST_RA2_ACK: begin
        if (status == ST_RA_ACK && ten) begin
          act = ACT_ADDR2;
          nxt = XS_WADDR2;
        end else if (left == '0) begin
          act = ACT_STOP;
        end else begin
          act     = ACT_CONT;
          nxt     = XS_WDATA;
          clr_ack = (left == ONE) || abort;
        end
      end
      ST_RD_ACK: begin
        act      = ACT_RECV;
        nxt      = XS_WDATA;
        dec_left = 1'b1;
        clr_ack  = (left == TWO) || abort;
      end
      ST_RD_NACK: act = ACT_RECV_STOP;
      ST_WA_NACK, ST_WD_NACK, ST_RA_NACK: begin
        act      = ACT_STOP;
        fail     = 1'b1;
        fail_res = RES_NODEV;
      end
      default: begin
        act  = ACT_RESET_STOP;
        fail = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/i2cseq_wdog.sv
module i2cseq_wdog #(
  parameter int TO_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            clear,
  input  logic [TO_W-1:0] limit,
  output logic            warn,
  output logic            kill
);
  logic [TO_W-1:0] cnt_q, cnt_d;
  logic            stage_q, stage_d;
  logic            kill_q, kill_d;
  logic            hit;

  always_comb begin
    hit     = run && !kill_q && (cnt_q == limit - 1'b1);
    cnt_d   = cnt_q;
    stage_d = stage_q;
    kill_d  = kill_q;
    if (clear) begin
      cnt_d   = '0;
      stage_d = 1'b0;
      kill_d  = 1'b0;
    end else if (run && !kill_q) begin
      if (hit) begin
        cnt_d = '0;
        if (stage_q) kill_d  = 1'b1;
        else         stage_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      stage_q <= 1'b0;
      kill_q  <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      stage_q <= stage_d;
      kill_q  <= kill_d;
    end
  end

  assign warn = hit && !clear && !stage_q;
  assign kill = kill_q;

  AST_KILL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (kill && !clear) |=> kill);  // R11
endmodule

// File: rtl/i2c_xfer_seq.sv
module i2c_xfer_seq
  import i2cseq_pkg::*;
#(
  parameter int LEN_W = 8,
  parameter int TO_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [9:0]       tgt_addr,
  input  logic             ten_bit,
  input  logic             rd,
  input  logic             rev_dir,
  input  logic             no_start,
  input  logic [LEN_W-1:0] xfer_len,
  input  logic             abort_req,
  input  logic [TO_W-1:0]  timeout_lim,
  input  logic [7:0]       tx_data,
  output logic             tx_pop,
  output logic [7:0]       rx_data,
  output logic             rx_valid,
  input  logic             eng_irq,
  output logic             bus_wr,
  output logic             bus_rd,
  output logic [1:0]       bus_addr,
  output logic [7:0]       bus_wdata,
  input  logic [7:0]       bus_rdata,
  output logic             busy,
  output logic             done,
  output logic [1:0]       result
);
  ustate_t          us_q, us_d;
  xstate_t          xs_q, xs_d;
  act_t             act_q, act_d;
  res_t             res_q, res_d;
  logic [LEN_W-1:0] left_q, left_d;
  logic             sent_q, sent_d;
  logic             abort_q, abort_d;
  logic             toab_q, toab_d;
  logic [7:0]       ctl_q, ctl_d;
  logic [9:0]       addr_q, addr_d;
  logic             ten_q, ten_d, rd_q, rd_d, rev_q, rev_d;

  logic [7:0] a1, a2, ctl_word;
  act_t       dec_act;
  xstate_t    dec_nxt;
  logic       dec_left, dec_clr, dec_fail, stopping, accept;
  res_t       dec_res;
  logic       wd_warn, wd_kill;

  i2cseq_addr u_addr (
    .addr(addr_q), .ten(ten_q), .rd(rd_q), .rev(rev_q),
    .first_byte(a1), .second_byte(a2)
  );

  i2cseq_decode #(.LEN_W(LEN_W)) u_dec (
    .status(bus_rdata), .ten(ten_q), .left(left_q), .sent_any(sent_q),
    .abort(abort_q), .act(dec_act), .nxt(dec_nxt), .dec_left(dec_left),
    .clr_ack(dec_clr), .fail(dec_fail), .fail_res(dec_res)
  );

  i2cseq_wdog #(.TO_W(TO_W)) u_wdog (
    .clk(clk), .rst_n(rst_n), .run(busy), .clear(accept),
    .limit(timeout_lim), .warn(wd_warn), .kill(wd_kill)
  );

  assign busy     = (xs_q != XS_IDLE);
  assign accept   = (us_q == U_WAIT) && !busy && start;
  assign stopping = (act_q == ACT_STOP) || (act_q == ACT_RECV_STOP) ||
                    (act_q == ACT_RESET_STOP);

  always_comb begin
    ctl_word = ctl_q;
    if (act_q == ACT_RESET_STOP) ctl_word = CTL_EN | CTL_STOP;
    else if (stopping)           ctl_word = (ctl_q & ~CTL_IE) | CTL_STOP;
    else if (act_q == ACT_START) ctl_word = ctl_q | CTL_START;
  end

  // Bus and stream outputs decoded from the micro-state
  always_comb begin
    bus_wr    = 1'b0;
    bus_rd    = 1'b0;
    bus_addr  = REG_DATA;
    bus_wdata = 8'h00;
    case (us_q)
      U_WAIT: if (busy && !wd_kill && eng_irq) begin
        bus_rd   = 1'b1;
        bus_addr = REG_STAT;
      end
      U_DRD:  bus_rd = 1'b1;
      U_DWR: begin
        bus_wr    = 1'b1;
        bus_wdata = (act_q == ACT_ADDR1) ? a1 :
                    (act_q == ACT_ADDR2) ? a2 : tx_data;
      end
      U_SRST: begin
        bus_wr   = 1'b1;
        bus_addr = REG_SRST;
      end
      U_CTL: begin
        bus_wr    = 1'b1;
        bus_addr  = REG_CTL;
        bus_wdata = ctl_word;
      end
      default: ;
    endcase
  end

  assign tx_pop   = (us_q == U_DWR) && (act_q == ACT_SEND);
  assign rx_valid = (us_q == U_DCAP);
  assign rx_data  = bus_rdata;
  assign done     = (us_q == U_CTL) && stopping && busy;
  assign result   = res_q;

  // Next-state logic
  always_comb begin
    us_d = us_q;     xs_d = xs_q;     act_d = act_q;   res_d = res_q;
    left_d = left_q; sent_d = sent_q; abort_d = abort_q; toab_d = toab_q;
    ctl_d = ctl_q;   addr_d = addr_q; ten_d = ten_q;   rd_d = rd_q;
    rev_d = rev_q;
    if (busy && abort_req) abort_d = 1'b1;
    if (wd_warn) begin
      abort_d = 1'b1;
      toab_d  = 1'b1;
    end
    case (us_q)
      U_WAIT: begin
        if (!busy) begin
          if (start) begin
            addr_d  = tgt_addr;
            ten_d   = ten_bit;
            rd_d    = rd;
            rev_d   = rev_dir;
            left_d  = xfer_len;
            sent_d  = 1'b0;
            abort_d = 1'b0;
            toab_d  = 1'b0;
            ctl_d   = CTL_EN | CTL_IE | CTL_ACK;
            res_d   = RES_OK;
            if (no_start && rd) begin
              act_d = ACT_CONT;
              xs_d  = XS_WDATA;
              us_d  = U_CTL;
            end else if (no_start) begin
              act_d  = ACT_SEND;
              xs_d   = XS_WACK;
              left_d = xfer_len - 1'b1;
              us_d   = U_DWR;
            end else begin
              act_d = ACT_START;
              xs_d  = XS_WSTART;
              us_d  = U_CTL;
            end
          end else if (eng_irq) begin
            act_d = ACT_STOP;
            us_d  = U_CTL;
          end
        end else if (wd_kill) begin
          act_d = ACT_RESET_STOP;
          res_d = RES_TIMEOUT;
          us_d  = U_SRST;
        end else if (eng_irq) begin
          us_d = U_STAT;
        end
      end
      U_STAT: begin
        act_d = dec_act;
        xs_d  = dec_nxt;
        if (dec_left) left_d = left_q - 1'b1;
        if (dec_clr)  ctl_d  = ctl_q & ~CTL_ACK;
        if (dec_fail) res_d = dec_res;
        else          res_d = toab_q ? RES_TIMEOUT : RES_OK;
        if (dec_nxt == XS_IDLE) xs_d = xs_q;  // leave idle at the stop write
        case (dec_act)
          ACT_ADDR1, ACT_ADDR2, ACT_SEND: us_d = U_DWR;
          ACT_RECV, ACT_RECV_STOP:        us_d = U_DRD;
          ACT_RESET_STOP:                 us_d = U_SRST;
          default:                        us_d = U_CTL;
        endcase
      end
      U_DRD:  us_d = U_DCAP;
      U_DCAP: begin
        sent_d = 1'b1;
        us_d   = U_CTL;
      end
      U_DWR: begin
        if (act_q == ACT_SEND) sent_d = 1'b1;
        us_d = U_CTL;
      end
      U_SRST: us_d = U_CTL;
      U_CTL: begin
        if (stopping) begin
          xs_d  = XS_IDLE;
          ctl_d = ctl_q & ~CTL_IE;
        end
        us_d = U_WAIT;
      end
      default: us_d = U_WAIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      us_q <= U_WAIT;   xs_q <= XS_IDLE;  act_q <= ACT_CONT; res_q <= RES_OK;
      left_q <= '0;     sent_q <= 1'b0;   abort_q <= 1'b0;   toab_q <= 1'b0;
      ctl_q <= 8'h00;   addr_q <= '0;     ten_q <= 1'b0;     rd_q <= 1'b0;
      rev_q <= 1'b0;
    end else begin
      us_q <= us_d;     xs_q <= xs_d;     act_q <= act_d;    res_q <= res_d;
      left_q <= left_d; sent_q <= sent_d; abort_q <= abort_d; toab_q <= toab_d;
      ctl_q <= ctl_d;   addr_q <= addr_d; ten_q <= ten_d;    rd_q <= rd_d;
      rev_q <= rev_d;
    end
  end

  AST_ONE_BUS_OP: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_rd));  // R14
  AST_DONE_WITH_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (bus_wr && bus_addr == REG_CTL && bus_wdata[4]));  // R14
  AST_POP_ON_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |-> (bus_wr && bus_addr == REG_DATA));  // R5
  AST_RX_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(bus_rd && bus_addr == REG_DATA));  // R6
  AST_EIO_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    (done && result == 2'd2) |-> $past(bus_wr && bus_addr == REG_SRST));  // R9
  AST_IRQ_READS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == REG_STAT) |=> (us_q == U_STAT));  // R2
endmodule

// File: tb/i2c_xfer_seq_test.sv
`timescale 1ns/1ps
module i2c_xfer_seq_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       start, ten_bit, rd, rev_dir, no_start, abort_req;
  logic [9:0] tgt_addr;
  logic [7:0] xfer_len;
  logic [15:0] timeout_lim;
  logic [7:0] tx_data, rx_data, bus_wdata, bus_rdata;
  logic       tx_pop, rx_valid, eng_irq, bus_wr, bus_rd, busy, done;
  logic [1:0] bus_addr, result;

  always #4 clk = ~clk;

  i2c_xfer_seq uut (
    .clk(clk), .rst_n(rst_n), .start(start), .tgt_addr(tgt_addr),
    .ten_bit(ten_bit), .rd(rd), .rev_dir(rev_dir), .no_start(no_start),
    .xfer_len(xfer_len), .abort_req(abort_req), .timeout_lim(timeout_lim),
    .tx_data(tx_data), .tx_pop(tx_pop), .rx_data(rx_data), .rx_valid(rx_valid),
    .eng_irq(eng_irq), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy), .done(done),
    .result(result)
  );

  int compared = 0, mismatched = 0, done_cnt = 0, cyc = 0;
  string tag = "R1";
  int exp_op[$], exp_rx[$], st_q[$], dl_q[$], rx_src[$];
  int exp_res = 0;
  logic poke = 1'b0;
  logic [7:0] tx_mem [0:7];
  logic [7:0] tx_idx = 8'd0, tx_base = 8'd0;
  logic [7:0] cur_st = 8'h00;
  int wait_cnt = 0;
  logic pend = 1'b0;

  assign tx_data = tx_mem[3'(tx_idx - tx_base)];

  task automatic check(input string t, input logic ok, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", t, act, exp);
    end
  endtask

  // Engine model: flag raised a scripted delay after each continuing control write
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (tx_pop) tx_idx <= tx_idx + 8'd1;
    if (poke) eng_irq <= 1'b1;
    if (bus_wr && (bus_addr == 2'd1 || bus_addr == 2'd3)) eng_irq <= 1'b0;
    if (bus_wr && bus_addr == 2'd1 && !bus_wdata[4] && st_q.size() > 0) begin
      wait_cnt <= dl_q[0];
      pend <= 1'b1;
    end
    if (pend) begin
      if (wait_cnt <= 1) begin
        eng_irq <= 1'b1;
        cur_st <= 8'(st_q.pop_front());
        void'(dl_q.pop_front());
        pend <= 1'b0;
      end else wait_cnt <= wait_cnt - 1;
    end
    if (bus_rd) begin
      if (bus_addr == 2'd2) bus_rdata <= cur_st;
      else bus_rdata <= (rx_src.size() > 0) ? 8'(rx_src.pop_front()) : 8'h00;
    end
  end

  // Reference comparison on every clock
  always @(negedge clk) begin
    if (rst_n) begin
      if (bus_wr || bus_rd) begin
        int op;
        op = int'({bus_wr, bus_addr, (bus_wr ? bus_wdata : 8'h00)});
        if (exp_op.size() == 0) check(tag, 1'b0, op, -1);
        else begin
          int e;
          e = exp_op.pop_front();
          check(tag, op == e, op, e);
        end
      end
      if (rx_valid) begin
        if (exp_rx.size() == 0) check(tag, 1'b0, rx_data, -1);
        else begin
          int e;
          e = exp_rx.pop_front();
          check(tag, rx_data == 8'(e), rx_data, e);
        end
      end
      if (done) begin
        done_cnt++;
        check(tag, result == 2'(exp_res), result, exp_res);
      end
    end
  end

  always @(posedge clk) begin
    if (cyc > 150000) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic ew(input int a, input int d); exp_op.push_back((1 << 10) | (a << 8) | d); endtask
  task automatic er(input int a); exp_op.push_back(a << 8); endtask
  task automatic es(input int s, input int d); st_q.push_back(s); dl_q.push_back(d); endtask
  task automatic erx(input int b); rx_src.push_back(b); exp_rx.push_back(b); endtask

  task automatic run(input string t, input int a, input logic ten, input logic r,
                     input logic rev, input logic ns, input int len, input int tl,
                     input logic ab, input int res);
    int d0;
    tag = t;
    exp_res = res;
    d0 = done_cnt;
    @(negedge clk);
    tx_base = tx_idx;
    tgt_addr = 10'(a); ten_bit = ten; rd = r; rev_dir = rev; no_start = ns;
    xfer_len = 8'(len); timeout_lim = 16'(tl); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (ab) abort_req = 1'b1;
    for (int n = 0; n < 3000 && done_cnt == d0; n++) @(posedge clk);
    @(negedge clk);
    abort_req = 1'b0;
    repeat (4) @(negedge clk);
    check(t, done_cnt == d0 + 1, done_cnt - d0, 1);
    check(t, exp_op.size() == 0, exp_op.size(), 0);
    check(t, exp_rx.size() == 0, exp_rx.size(), 0);
  endtask

  initial begin
    eng_irq = 1'b0; bus_rdata = 8'h00;
    start = 0; ten_bit = 0; rd = 0; rev_dir = 0; no_start = 0; abort_req = 0;
    tgt_addr = '0; xfer_len = '0; timeout_lim = 16'd1000;
    for (int i = 0; i < 8; i++) tx_mem[i] = 8'h00;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: quiet after reset
    check("R1", !bus_wr && !bus_rd && !busy && !done && !tx_pop && !rx_valid,
          {bus_wr, bus_rd, busy, done, tx_pop, rx_valid}, 0);

    // R12: flag while idle answered with a stop, no done
    tag = "R12";
    ew(1, 8'h10);
    poke = 1'b1; @(negedge clk); poke = 1'b0;
    repeat (6) @(negedge clk);
    check("R12", exp_op.size() == 0, exp_op.size(), 0);
    check("R12", done_cnt == 0, done_cnt, 0);

    // R2 R3 R5: 7-bit write of two bytes
    tx_mem[0] = 8'hA5; tx_mem[1] = 8'h3C;
    es(8'h08,3); es(8'h18,3); es(8'h28,3); es(8'h28,3);
    ew(1,8'h0F); er(2); ew(0,8'hA0); ew(1,8'h07); er(2); ew(0,8'hA5); ew(1,8'h07);
    er(2); ew(0,8'h3C); ew(1,8'h07); er(2); ew(1,8'h15);
    run("R5", 10'h050, 0, 0, 0, 0, 2, 1000, 0, 0);

    // R3 R6: reversed-direction read of three bytes
    es(8'h08,3); es(8'h40,3); es(8'h50,3); es(8'h50,3); es(8'h58,3);
    erx(8'h11); erx(8'h22); erx(8'h33);
    ew(1,8'h0F); er(2); ew(0,8'h47); ew(1,8'h07); er(2); ew(1,8'h07);
    er(2); er(0); ew(1,8'h07); er(2); er(0); ew(1,8'h03); er(2); er(0); ew(1,8'h11);
    run("R6", 10'h023, 0, 0, 1, 0, 3, 1000, 0, 0);

    // R4: 10-bit write
    tx_mem[0] = 8'h77;
    es(8'h08,2); es(8'h18,2); es(8'hD0,2); es(8'h28,2);
    ew(1,8'h0F); er(2); ew(0,8'hF4); ew(1,8'h07); er(2); ew(0,8'hA5); ew(1,8'h07);
    er(2); ew(0,8'h77); ew(1,8'h07); er(2); ew(1,8'h15);
    run("R4", 10'h2A5, 1, 0, 0, 0, 1, 1000, 0, 0);

    // R7: 10-bit read of zero length
    es(8'h08,2); es(8'h40,2); es(8'hE0,2);
    ew(1,8'h0F); er(2); ew(0,8'hF3); ew(1,8'h07); er(2); ew(0,8'hC3); ew(1,8'h07);
    er(2); ew(1,8'h15);
    run("R7", 10'h1C3, 1, 1, 0, 0, 0, 1000, 0, 0);

    // R8: address not acknowledged
    es(8'h08,2); es(8'h20,2);
    ew(1,8'h0F); er(2); ew(0,8'h20); ew(1,8'h07); er(2); ew(1,8'h15);
    run("R8", 10'h010, 0, 0, 0, 0, 1, 1000, 0, 1);

    // R9: unexpected status
    es(8'h08,2); es(8'h38,2);
    ew(1,8'h0F); er(2); ew(0,8'h20); ew(1,8'h07); er(2); ew(3,8'h00); ew(1,8'h11);
    run("R9", 10'h010, 0, 0, 0, 0, 1, 1000, 0, 2);

    // R13: no-start write then no-start read
    tx_mem[0] = 8'h9A; tx_mem[1] = 8'hBC;
    es(8'h28,2); es(8'h28,2);
    ew(0,8'h9A); ew(1,8'h07); er(2); ew(0,8'hBC); ew(1,8'h07); er(2); ew(1,8'h15);
    run("R13", 10'h010, 0, 0, 0, 1, 2, 1000, 0, 0);
    es(8'h58,2); erx(8'h5E);
    ew(1,8'h07); er(2); er(0); ew(1,8'h15);
    run("R13", 10'h010, 0, 1, 0, 1, 1, 1000, 0, 0);

    // R10: external abort on a write, then on a read
    tx_mem[0] = 8'h01; tx_mem[1] = 8'h02; tx_mem[2] = 8'h03;
    es(8'h08,2); es(8'h18,2); es(8'h28,2);
    ew(1,8'h0F); er(2); ew(0,8'h20); ew(1,8'h07); er(2); ew(0,8'h01); ew(1,8'h07);
    er(2); ew(1,8'h15);
    run("R10", 10'h010, 0, 0, 0, 0, 3, 1000, 1, 0);
    es(8'h08,2); es(8'h40,2); es(8'h58,2); erx(8'h44);
    ew(1,8'h0F); er(2); ew(0,8'h21); ew(1,8'h07); er(2); ew(1,8'h03);
    er(2); er(0); ew(1,8'h11);
    run("R10", 10'h010, 0, 1, 0, 0, 3, 1000, 1, 0);

    // R11: first expiry winds down, second expiry resets the engine
    tx_mem[0] = 8'h55; tx_mem[1] = 8'h66;
    es(8'h08,3); es(8'h18,3); es(8'h28,40);
    ew(1,8'h0F); er(2); ew(0,8'h20); ew(1,8'h07); er(2); ew(0,8'h55); ew(1,8'h07);
    er(2); ew(1,8'h15);
    run("R11", 10'h010, 0, 0, 0, 0, 2, 40, 0, 3);
    es(8'h08,2);
    ew(1,8'h0F); er(2); ew(0,8'h20); ew(1,8'h07); ew(3,8'h00); ew(1,8'h11);
    run("R11", 10'h010, 0, 0, 0, 0, 1, 30, 0, 3);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule